// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block owns the active-low chip-select line of a SPI memory master. It wraps every burst in up to three chip-select-low phases: an optional preparation phase before data, the data phase itself, and an optional completion phase after data. Once chip-select rises, the block enforces a minimum deselect gap before it accepts another burst. The transfer engine requests a burst with a level `start`, sees `busy` while chip-select is low, and pulses `data_done` when the last data bit has gone out. The block answers with a one-cycle `done` when chip-select rises, and raises `ready` once a new burst may begin.

The SPI clock is a clock-enable pulse, `sclk_en`, in the core clock domain. The preparation and completion lengths count those pulses. The deselect gap counts core clock cycles. One 32-bit configuration word holds every timing field. An ECC-mode input lengthens the completion phase by an extra count. The register also keeps three ECC option bits that software can read back, and the sequencer does not use them.

Top module: `csel_timer`

## Requirements
- R1: After synchronous reset the configuration word reads 0x0000B084, `cs_n` is 1, `ready` is 1, and `busy`, `done`, `ph_prep`, `ph_data` and `ph_hold` are 0.
- R2: Configuration bits 31 and 23:17 always read 0 and ignore writes. Every other bit reads back the last value written, including the stored-only ECC option bits 15, 16 and 24.
- R3: When bit 0 (setup enable) is 1, an accepted burst first enters the preparation phase with `cs_n` low. It stays there for exactly (bits 6:2)+1 `sclk_en` pulses and then enters the data phase.
- R4: When bit 0 is 0, an accepted burst goes straight to the data phase, with `cs_n` low from the first cycle after acceptance, and `ph_prep` never rises.
- R5: When bit 1 (hold enable) is 1 and ECC mode is off, `cs_n` stays low through a completion phase that spans exactly N = bits 11:7 `sclk_en` pulses. If N is 0, the completion phase is skipped.
- R6: When `ecc_mode` is 1, the completion length N is bits 11:7 plus bits 14:12.
- R7: When bit 1 is 0, or N is 0, `cs_n` is high in the cycle after the cycle in which `data_done` is sampled during the data phase.
- R8: With G = bits 30:25, `cs_n` stays high for exactly G+1 core cycles between bursts while `start` is held. `ready` is low during the first G of those cycles, and a request made then is held off.
- R9: `done` is a single-cycle pulse in the first cycle `cs_n` is high after a burst. `busy` is high exactly when `cs_n` is low.
- R10: The preparation and completion counts advance only on `sclk_en`, so with `sclk_en` stopped the block stays in the preparation phase. The deselect gap advances on every core cycle even with `sclk_en` stopped.
- R11: The data phase lasts until `data_done`, however many `sclk_en` pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| sclk_en | input | 1 | One-cycle pulse per SPI clock period |
| ecc_mode | input | 1 | Adds the extra completion count when 1 |
| start | input | 1 | Burst request, held until `busy` rises |
| data_done | input | 1 | Last data-phase cycle strobe from the transfer engine |
| cs_n | output | 1 | Active-low chip-select |
| busy | output | 1 | Chip-select is asserted |
| done | output | 1 | One-cycle pulse when chip-select is released |
| ready | output | 1 | A new burst will be accepted this cycle |
| ph_prep | output | 1 | Preparation phase indicator |
| ph_data | output | 1 | Data phase indicator |
| ph_hold | output | 1 | Completion phase indicator |

## Verification
The hardest situation to reach from the ports is a request that lands inside a running deselect gap. The bench reaches it by raising `start` again in the very cycle `done` pulses. It then counts the high cycles of `cs_n` until the second burst pulls it low, which must equal the gap field plus one. The dependence of the phase counts on `sclk_en` is exposed by stopping that pulse entirely. With `sclk_en` stopped, the bench confirms that the preparation phase freezes while the gap still expires on schedule. A single pulse after restart must then release the preparation phase.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int REG_W      = 32;
  localparam int SETUP_W    = 5;
  localparam int HOLD_W     = 5;
  localparam int EXTRA_W    = 3;
  localparam int GAP_W      = 6;

  localparam int POS_SETUP_EN = 0;
  localparam int POS_HOLD_EN  = 1;
  localparam int POS_SETUP    = 2;
  localparam int POS_HOLD     = 7;
  localparam int POS_EXTRA    = 12;
  localparam int POS_GAP      = 25;

  localparam logic [REG_W-1:0] REG_RESET = 32'h0000_B084;
  // writable: bits 16:0 and 30:24
  localparam logic [REG_W-1:0] REG_MASK  = 32'h7F01_FFFF;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PREP = 3'd1,
    S_DATA = 3'd2,
    S_HOLD = 3'd3,
    S_GAP  = 3'd4
  } phase_e;
endpackage

// File: rtl/csel_cfg_reg.sv
module csel_cfg_reg #(
  parameter int               DW    = 32,
  parameter logic [DW-1:0]    RST_V = '0,
  parameter logic [DW-1:0]    WMASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_V & WMASK;
    else if (we) q <= wdata & WMASK;
  end

  // R2: bits outside the writable mask never become set
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (q & ~WMASK) == '0);
endmodule

// File: rtl/csel_down_cnt.sv
module csel_down_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/csel_fsm.sv
module csel_fsm
  import csel_pkg::*;
#(
  parameter int SW = 5,
  parameter int PW = 6,
  parameter int GW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          data_done,
  input  logic          sclk_en,
  input  logic          setup_en,
  input  logic          hold_en,
  input  logic [SW-1:0] setup_len,
  input  logic [PW-1:0] hold_len,
  input  logic [GW-1:0] gap_len,
  input  logic [PW-1:0] pcnt,
  input  logic          pzero,
  input  logic          gzero,
  output logic          p_load,
  output logic [PW-1:0] p_val,
  output logic          p_dec,
  output logic          g_load,
  output logic [GW-1:0] g_val,
  output logic          g_dec,
  output logic          cs_n,
  output logic          busy,
  output logic          done,
  output logic          ready,
  output logic          ph_prep,
  output logic          ph_data,
  output logic          ph_hold
);
  phase_e st_q, nxt;
  logic   nxt_low;

  assign ready = (st_q == S_IDLE) || (st_q == S_GAP && gzero);

  always_comb begin
    nxt    = st_q;
    p_load = 1'b0;
    p_val  = '0;
    p_dec  = 1'b0;
    g_load = 1'b0;
    g_val  = gap_len;
    g_dec  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          p_load = 1'b1;
          p_val  = PW'(setup_len);
          nxt    = setup_en ? S_PREP : S_DATA;
        end
      end
      S_PREP: begin
        if (sclk_en) begin
          if (pzero) nxt = S_DATA;
          else       p_dec = 1'b1;
        end
      end
      S_DATA: begin
        if (data_done) begin
          if (hold_en && hold_len != '0) begin
            nxt    = S_HOLD;
            p_load = 1'b1;
            p_val  = hold_len - 1'b1;
          end else begin
            nxt    = S_GAP;
            g_load = 1'b1;
          end
        end
      end
      S_HOLD: begin
        if (sclk_en) begin
          if (pzero) begin
            nxt    = S_GAP;
            g_load = 1'b1;
          end else begin
            p_dec = 1'b1;
          end
        end
      end
      S_GAP: begin
        if (!gzero) begin
          g_dec = 1'b1;
        end else if (start) begin
          p_load = 1'b1;
          p_val  = PW'(setup_len);
          nxt    = setup_en ? S_PREP : S_DATA;
        end else begin
          nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign nxt_low = (nxt == S_PREP) || (nxt == S_DATA) || (nxt == S_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      cs_n    <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      ph_prep <= 1'b0;
      ph_data <= 1'b0;
      ph_hold <= 1'b0;
    end else begin
      st_q    <= nxt;
      cs_n    <= !nxt_low;
      busy    <= nxt_low;
      done    <= (st_q == S_DATA || st_q == S_HOLD) && nxt == S_GAP;
      ph_prep <= (nxt == S_PREP);
      ph_data <= (nxt == S_DATA);
      ph_hold <= (nxt == S_HOLD);
    end
  end

  // R8: while the gap counter is non-zero chip-select stays released
  a_r8_gap_keeps_high: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_GAP && !gzero) |=> cs_n);

  // R7: without a completion phase, data_done releases chip-select next cycle
  a_r7_release_no_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DATA && data_done && !hold_en) |=> (cs_n && st_q == S_GAP));

  // R4: setup disabled skips the preparation phase
  a_r4_skip_prep: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && start && !setup_en) |=> (st_q == S_DATA && !cs_n));

  // R10: phase counter frozen between SPI clock pulses
  a_r10_count_on_sclk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == S_PREP || st_q == S_HOLD) && !sclk_en) |=> $stable(pcnt));

  // R9: release pulse lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/csel_timer.sv
module csel_timer
  import csel_pkg::*;
#(
  parameter int SW = SETUP_W,
  parameter int HW = HOLD_W,
  parameter int EW = EXTRA_W,
  parameter int GW = GAP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             sclk_en,
  input  logic             ecc_mode,
  input  logic             start,
  input  logic             data_done,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic             ready,
  output logic             ph_prep,
  output logic             ph_data,
  output logic             ph_hold
);
  localparam int SUM_W = ((HW > EW) ? HW : EW) + 1;
  localparam int PW    = (SW > SUM_W) ? SW : SUM_W;

  logic [REG_W-1:0] cfg_q;
  logic             setup_en, hold_en;
  logic [SW-1:0]    setup_len;
  logic [HW-1:0]    hold_base;
  logic [EW-1:0]    hold_extra;
  logic [GW-1:0]    gap_len;
  logic [PW-1:0]    hold_len;

  logic          p_load, p_dec, pzero;
  logic [PW-1:0] p_val, pcnt;
  logic          g_load, g_dec, gzero;
  logic [GW-1:0] g_val, gcnt;

  csel_cfg_reg #(.DW(REG_W), .RST_V(REG_RESET), .WMASK(REG_MASK)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  assign cfg_rdata  = cfg_q;
  assign setup_en   = cfg_q[POS_SETUP_EN];
  assign hold_en    = cfg_q[POS_HOLD_EN];
  assign setup_len  = cfg_q[POS_SETUP +: SW];
  assign hold_base  = cfg_q[POS_HOLD  +: HW];
  assign hold_extra = cfg_q[POS_EXTRA +: EW];
  assign gap_len    = cfg_q[POS_GAP   +: GW];
  assign hold_len   = PW'(hold_base) + (ecc_mode ? PW'(hold_extra) : PW'(0));

  csel_down_cnt #(.W(PW)) u_phase_cnt (
    .clk(clk), .rst(rst), .load(p_load), .load_val(p_val), .dec(p_dec),
    .cnt(pcnt), .zero(pzero)
  );

  csel_down_cnt #(.W(GW)) u_gap_cnt (
    .clk(clk), .rst(rst), .load(g_load), .load_val(g_val), .dec(g_dec),
    .cnt(gcnt), .zero(gzero)
  );

  csel_fsm #(.SW(SW), .PW(PW), .GW(GW)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .data_done(data_done),
    .sclk_en(sclk_en), .setup_en(setup_en), .hold_en(hold_en),
    .setup_len(setup_len), .hold_len(hold_len), .gap_len(gap_len),
    .pcnt(pcnt), .pzero(pzero), .gzero(gzero),
    .p_load(p_load), .p_val(p_val), .p_dec(p_dec),
    .g_load(g_load), .g_val(g_val), .g_dec(g_dec),
    .cs_n(cs_n), .busy(busy), .done(done), .ready(ready),
    .ph_prep(ph_prep), .ph_data(ph_data), .ph_hold(ph_hold)
  );

  // R9: busy mirrors the asserted chip-select
  a_r9_busy_is_low_cs: assert property (@(posedge clk) disable iff (rst)
    busy == !cs_n);

  // R8: gap counter never runs while chip-select is asserted
  a_r8_gap_idle_in_burst: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !done) |-> $stable(gcnt) || g_load);
endmodule

// File: tb/csel_timer_test.sv
module csel_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sclk_en = 1'b0;
  logic        ecc_mode = 1'b0;
  logic        start = 1'b0;
  logic        data_done = 1'b0;
  logic        cs_n, busy, done, ready, ph_prep, ph_data, ph_hold;

  int nchk = 0;
  int nfail = 0;
  int sk_period = 1;
  int sk_phase = 0;

  always #2 clk = ~clk;

  csel_timer uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sclk_en(sclk_en), .ecc_mode(ecc_mode),
    .start(start), .data_done(data_done), .cs_n(cs_n), .busy(busy),
    .done(done), .ready(ready), .ph_prep(ph_prep), .ph_data(ph_data),
    .ph_hold(ph_hold)
  );

  // SPI clock enable: one pulse every sk_period cycles, none when 0
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sk_period <= 0) begin
        sclk_en = 1'b0;
      end else begin
        if (sk_phase >= sk_period) sk_phase = 0;
        sclk_en = (sk_phase == 0);
        sk_phase = sk_phase + 1;
      end
    end
  end

  localparam int NV = 7;
  localparam int T_SE [NV] = '{1, 1, 0, 1, 0, 1, 1};
  localparam int T_HE [NV] = '{1, 1, 1, 0, 0, 1, 1};
  localparam int T_ST [NV] = '{2, 0, 5, 3, 0, 4, 1};
  localparam int T_HT [NV] = '{3, 1, 2, 7, 0, 31, 0};
  localparam int T_EX [NV] = '{2, 3, 1, 7, 0, 7, 0};
  localparam int T_GP [NV] = '{4, 0, 2, 7, 1, 63, 3};
  localparam int T_EC [NV] = '{0, 1, 0, 1, 0, 1, 0};
  localparam int T_SK [NV] = '{1, 3, 2, 1, 2, 2, 1};
  localparam int T_LN [NV] = '{3, 1, 2, 4, 1, 2, 2};

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_ready();
    for (int g = 0; g < 2000 && !ready; g++) @(negedge clk);
  endtask

  // runs one burst (start already raised) and returns at the done cycle
  task automatic drive_burst(input int len, output int pp, output int hp,
                             output int dc, output int dn);
    pp = 0; hp = 0; dc = 0; dn = 0;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (busy) start = 1'b0;
      if (ph_prep && sclk_en) pp++;
      if (ph_hold && sclk_en) hp++;
      data_done = 1'b0;
      if (ph_data) begin
        dc++;
        if (dc == len) data_done = 1'b1;
      end
      if (done) begin
        dn++;
        break;
      end
    end
    data_done = 1'b0;
  endtask

  // called at the done cycle: re-requests and counts high cycles
  task automatic measure_gap(output int gc, output int rdy0);
    rdy0 = ready;
    start = 1'b1;
    gc = 1;
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (cs_n) gc++;
      else break;
    end
  endtask

  initial begin
    int pp, hp, dc, dn, gc, r0, n;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cfg reset", cfg_rdata, 32'h0000_B084);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 ready", ready, 1);
    chk("R1 busy/done", {busy, done}, 0);
    chk("R1 phases", {ph_prep, ph_data, ph_hold}, 0);

    write_cfg(32'hFFFF_FFFF);
    chk("R2 mask all ones", cfg_rdata, 32'h7F01_FFFF);
    write_cfg(32'h0101_8000);
    chk("R2 option bits stored", cfg_rdata, 32'h0101_8000);
    write_cfg(32'h80FE_0000);
    chk("R2 reserved ignored", cfg_rdata, 32'h0000_0000);

    for (int i = 0; i < NV; i++) begin
      w = 32'(T_SE[i]) | (32'(T_HE[i]) << 1) | (32'(T_ST[i]) << 2) |
          (32'(T_HT[i]) << 7) | (32'(T_EX[i]) << 12) | (32'(T_GP[i]) << 25);
      sk_period = T_SK[i];
      ecc_mode = T_EC[i][0];
      write_cfg(w);
      wait_ready();
      start = 1'b1;
      drive_burst(T_LN[i], pp, hp, dc, dn);
      chk(T_SE[i] != 0 ? "R3 prep pulses" : "R4 no prep", pp,
          T_SE[i] != 0 ? T_ST[i] + 1 : 0);
      n = T_HT[i] + (T_EC[i] != 0 ? T_EX[i] : 0);
      chk(T_EC[i] != 0 ? "R6 ecc hold pulses" : "R5 hold pulses", hp,
          (T_HE[i] != 0 && n != 0) ? n : 0);
      chk("R11 data cycles", dc, T_LN[i]);
      chk("R9 done once", dn, 1);
      chk("R9 cs_n at done", cs_n, 1);
      measure_gap(gc, r0);
      chk("R8 gap cycles", gc, T_GP[i] + 1);
      chk("R8 ready in first gap cycle", r0, T_GP[i] == 0 ? 1 : 0);
      drive_burst(1, pp, hp, dc, dn);
      chk("R9 second burst done", dn, 1);
    end

    // R7: hold disabled, cs_n high right after data_done is sampled
    sk_period = 1;
    ecc_mode = 1'b0;
    write_cfg(32'h0000_0F80);
    wait_ready();
    start = 1'b1;
    for (int g = 0; g < 100 && !ph_data; g++) begin
      @(negedge clk);
      if (busy) start = 1'b0;
    end
    start = 1'b0;
    data_done = 1'b1;
    @(negedge clk);
    data_done = 1'b0;
    chk("R7 cs_n after data_done", cs_n, 1);
    chk("R7 done with release", done, 1);

    // R10: preparation frozen without sclk_en
    sk_period = 0;
    write_cfg(32'h0000_0001);
    wait_ready();
    start = 1'b1;
    repeat (12) @(negedge clk);
    chk("R10 prep frozen", {ph_prep, cs_n}, 2'b10);
    sk_period = 1;
    drive_burst(2, pp, hp, dc, dn);
    chk("R10 prep resumes on one pulse", pp, 1);

    // R10/R11: gap counts core cycles and data waits with sclk_en stopped
    sk_period = 0;
    write_cfg(32'h0A00_0000);
    wait_ready();
    start = 1'b1;
    drive_burst(6, pp, hp, dc, dn);
    chk("R11 data without sclk", dc, 6);
    measure_gap(gc, r0);
    chk("R10 gap without sclk", gc, 6);
    drive_burst(1, pp, hp, dc, dn);
    chk("R4 no prep without setup", pp, 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule